// File: doc/BRIEF.md
# Serial-link PHY bring-up sequencer

This block runs the power-on bring-up of a serial storage link after one start pulse. It opens the controller clock gate and takes the reference PLL out of power-down. It waits for the PLL to report lock, then turns the PLL on and its 100 MHz output on in two separate writes. Next it asks an external PHY-access port to reset the PHY, and polls the PHY until its receive PLL reports ready. The last steps program the controller's capability, implemented-ports and one-millisecond timer registers.

All register traffic leaves on a write-only bus. Every read-modify-write is applied to a local shadow copy of the target register, so nothing is ever read back. PHY transactions are level requests that stay up until the access port answers with done or error. The run ends with a held `done`, or with a held `err` plus a code that names the step that failed.

Top module: `link_bringup_seq`

## Requirements
- R1: While the reset is asserted, and in the first cycles after it, `busy`, `done`, `err`, `wr_en` and `phy_req` are low and `fail_step` is 0.
- R2: A start pulse taken in the idle, done or failed state launches a run. The first write goes to the gate register and sets bits 5:4 to 11 while keeping every other bit.
- R3: The second write clears bit 12 (power-down) of the PLL register. The lock input is then sampled once per cycle for up to LOCK_POLLS cycles. Lock seen on the last sample is accepted. Otherwise the run fails with `fail_step` = 1 and issues no further writes.
- R4: After lock, one PLL write sets bit 13 and clears bit 16. A second, separate PLL write then sets bit 20.
- R5: The PHY reset is a write request (`phy_wr`=1) to PHY address 0x7F3F with data 0x0001. Each request holds `phy_req` and its address until `phy_done` or `phy_err` is seen.
- R6: Each status read (`phy_wr`=0, PHY address 0x2003) comes after exactly GAP_CYCLES idle cycles following the previous PHY answer. Receive-PLL ready means `phy_rdata` bit 1 is set. After PHY_POLLS reads without ready, the run fails with `fail_step` = 4.
- R7: After ready, three writes follow in this order: the capability register with bit SSS_BIT set, the ports register with bit 0 set, and the timer register written with BUS_HZ/1000. `done` is high in the same cycle as the timer write on the bus.
- R8: `phy_err` aborts the run. `fail_step` is 2 during the reset access and 3 during a status read. An error wins over a `phy_done` raised in the same cycle.
- R9: A start pulse while `busy` is high has no effect on the running sequence.
- R10: Each read-modify-write starts from the value last written to that register since reset, or from its reset parameter if none was written. This holds across runs.
- R11: `busy` is high from the cycle after an accepted start until the run ends. `done` and `err` then stay high until the next start, and `done` and `busy` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that launches a run |
| pll_lock | input | 1 | PLL lock flag |
| phy_done | input | 1 | PHY-access port finished the current request |
| phy_err | input | 1 | PHY-access port failed the current request |
| phy_rdata | input | PHY_DW | PHY read data, valid with `phy_done` |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | ADDR_W | Register write address |
| wr_data | output | DATA_W | Register write data |
| phy_req | output | 1 | PHY-access request, held until answered |
| phy_wr | output | 1 | 1 = PHY write, 0 = PHY read |
| phy_addr | output | PHY_AW | PHY register address |
| phy_wdata | output | PHY_DW | PHY write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed |
| err | output | 1 | Sequence aborted |
| fail_step | output | 3 | 0 none, 1 lock timeout, 2 reset access error, 3 status read error, 4 receive-PLL timeout |

## Verification
Two pairs of events can meet in one cycle. The first pair is the access port raising done and error together, which the bench provokes on the reset request and on a later status read. Those runs must end in the error state with the matching code and with no controller writes after the PLL writes. The second pair is the last timer write reaching the bus in the very cycle `done` rises; the scoreboard monitor checks `done` at the moment it pops that write. A related boundary, lock arriving on the final permitted sample against one cycle later, is driven at exact cycle offsets from the observed power-up write, and the two outcomes are judged as success and lock-timeout.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_GATE, ST_PWR, ST_LOCK, ST_EN, ST_OUT100, ST_PHYRST,
    ST_GAP, ST_POLL, ST_CAP, ST_PORTS, ST_TIMER, ST_DONE, ST_FAIL
  } seq_st_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_GATE, OP_PWR, OP_EN, OP_OUT100, OP_CAP, OP_PORTS, OP_TIMER
  } wr_op_t;

  typedef enum logic [2:0] {
    FS_NONE      = 3'd0,
    FS_LOCK      = 3'd1,
    FS_RST_ACC   = 3'd2,
    FS_POLL_ACC  = 3'd3,
    FS_RX_TMO    = 3'd4
  } fail_t;

  // Field positions other logic decodes
  localparam int GATE_LSB   = 4;
  localparam int PWRDN_BIT  = 12;
  localparam int PLLEN_BIT  = 13;
  localparam int BYPASS_BIT = 16;
  localparam int OUT100_BIT = 20;
  localparam int RXRDY_BIT  = 1;

  localparam logic [15:0] PHY_RST_REG  = 16'h7F3F;
  localparam logic [15:0] PHY_STAT_REG = 16'h2003;

endpackage

// File: rtl/bringup_count.sv
module bringup_count #(
  parameter int unsigned MAX_COUNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_last
);
  localparam int W = $clog2(MAX_COUNT + 1);

  logic [W-1:0] cnt_q, cnt_n;
  logic         upd;

  assign upd = clr | inc;

  always_comb begin
    cnt_n = cnt_q;
    if (clr)      cnt_n = '0;
    else if (inc) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_n;
  end

  assign at_last = (cnt_q == W'(MAX_COUNT - 1));

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !at_last)
    else $error("counter stepped past its last value");

endmodule

// File: rtl/bringup_wr_port.sv
module bringup_wr_port
  import bringup_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 32,
  parameter int unsigned       GATE_ADDR  = 0,
  parameter int unsigned       PLL_ADDR   = 0,
  parameter int unsigned       CAP_ADDR   = 0,
  parameter int unsigned       PORTS_ADDR = 0,
  parameter int unsigned       TIMER_ADDR = 0,
  parameter logic [DATA_W-1:0] GATE_RST   = '0,
  parameter logic [DATA_W-1:0] PLL_RST    = '0,
  parameter logic [DATA_W-1:0] CAP_RST    = '0,
  parameter logic [DATA_W-1:0] PORTS_RST  = '0,
  parameter int                SSS_BIT    = 27,
  parameter int unsigned       TIMER_VAL  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_op_t            op,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam logic [DATA_W-1:0] GATE_ON  = DATA_W'(3) << GATE_LSB;
  localparam logic [DATA_W-1:0] PWRDN_M  = DATA_W'(1) << PWRDN_BIT;
  localparam logic [DATA_W-1:0] PLLEN_M  = DATA_W'(1) << PLLEN_BIT;
  localparam logic [DATA_W-1:0] BYPASS_M = DATA_W'(1) << BYPASS_BIT;
  localparam logic [DATA_W-1:0] OUT100_M = DATA_W'(1) << OUT100_BIT;
  localparam logic [DATA_W-1:0] SSS_M    = DATA_W'(1) << SSS_BIT;

  logic [DATA_W-1:0] gate_q, gate_n, pll_q, pll_n, cap_q, cap_n, ports_q, ports_n;
  logic [DATA_W-1:0] data_n;
  logic [ADDR_W-1:0] addr_n;
  logic              en_n;

  always_comb begin
    en_n    = 1'b0;
    addr_n  = wr_addr;
    data_n  = wr_data;
    gate_n  = gate_q;
    pll_n   = pll_q;
    cap_n   = cap_q;
    ports_n = ports_q;
    unique case (op)
      OP_GATE: begin
        en_n = 1'b1; addr_n = ADDR_W'(GATE_ADDR);
        data_n = gate_q | GATE_ON; gate_n = data_n;
      end
      OP_PWR: begin
        en_n = 1'b1; addr_n = ADDR_W'(PLL_ADDR);
        data_n = pll_q & ~PWRDN_M; pll_n = data_n;
      end
      OP_EN: begin
        en_n = 1'b1; addr_n = ADDR_W'(PLL_ADDR);
        data_n = (pll_q | PLLEN_M) & ~BYPASS_M; pll_n = data_n;
      end
      OP_OUT100: begin
        en_n = 1'b1; addr_n = ADDR_W'(PLL_ADDR);
        data_n = pll_q | OUT100_M; pll_n = data_n;
      end
      OP_CAP: begin
        en_n = 1'b1; addr_n = ADDR_W'(CAP_ADDR);
        data_n = cap_q | SSS_M; cap_n = data_n;
      end
      OP_PORTS: begin
        en_n = 1'b1; addr_n = ADDR_W'(PORTS_ADDR);
        data_n = ports_q | DATA_W'(1); ports_n = data_n;
      end
      OP_TIMER: begin
        en_n = 1'b1; addr_n = ADDR_W'(TIMER_ADDR);
        data_n = DATA_W'(TIMER_VAL);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      gate_q  <= GATE_RST;
      pll_q   <= PLL_RST;
      cap_q   <= CAP_RST;
      ports_q <= PORTS_RST;
    end else begin
      wr_en <= en_n;
      if (en_n) begin
        wr_addr <= addr_n;
        wr_data <= data_n;
        gate_q  <= gate_n;
        pll_q   <= pll_n;
        cap_q   <= cap_n;
        ports_q <= ports_n;
      end
    end
  end

endmodule

// File: rtl/bringup_fsm.sv
module bringup_fsm
  import bringup_pkg::*;
#(
  parameter int PHY_AW = 16,
  parameter int PHY_DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pll_lock,
  input  logic              phy_done,
  input  logic              phy_err,
  input  logic              phy_rdy,
  input  logic              lock_last,
  input  logic              poll_last,
  input  logic              gap_last,
  output logic              lock_clr,
  output logic              lock_inc,
  output logic              poll_clr,
  output logic              poll_inc,
  output logic              gap_clr,
  output logic              gap_inc,
  output wr_op_t            op,
  output logic              phy_req,
  output logic              phy_wr,
  output logic [PHY_AW-1:0] phy_addr,
  output logic [PHY_DW-1:0] phy_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [2:0]        fail_step
);
  seq_st_t st_q, st_n;
  fail_t   fail_q, fail_n;
  logic    idle_like;

  assign idle_like = (st_q == ST_IDLE) || (st_q == ST_DONE) || (st_q == ST_FAIL);

  always_comb begin
    st_n   = st_q;
    fail_n = fail_q;
    unique case (st_q)
      ST_IDLE, ST_DONE, ST_FAIL: if (start) begin
        st_n = ST_GATE; fail_n = FS_NONE;
      end
      ST_GATE:   st_n = ST_PWR;
      ST_PWR:    st_n = ST_LOCK;
      ST_LOCK: begin
        if (pll_lock)       st_n = ST_EN;
        else if (lock_last) begin st_n = ST_FAIL; fail_n = FS_LOCK; end
      end
      ST_EN:     st_n = ST_OUT100;
      ST_OUT100: st_n = ST_PHYRST;
      ST_PHYRST: begin
        if (phy_err)       begin st_n = ST_FAIL; fail_n = FS_RST_ACC; end
        else if (phy_done) st_n = ST_GAP;
      end
      ST_GAP:    if (gap_last) st_n = ST_POLL;
      ST_POLL: begin
        if (phy_err) begin st_n = ST_FAIL; fail_n = FS_POLL_ACC; end
        else if (phy_done) begin
          if (phy_rdy)        st_n = ST_CAP;
          else if (poll_last) begin st_n = ST_FAIL; fail_n = FS_RX_TMO; end
          else                st_n = ST_GAP;
        end
      end
      ST_CAP:    st_n = ST_PORTS;
      ST_PORTS:  st_n = ST_TIMER;
      ST_TIMER:  st_n = ST_DONE;
      default:   st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      fail_q <= FS_NONE;
    end else begin
      st_q   <= st_n;
      fail_q <= fail_n;
    end
  end

  // Counter controls
  assign lock_clr = (st_q == ST_PWR);
  assign lock_inc = (st_q == ST_LOCK) && !pll_lock && !lock_last;
  assign poll_clr = (st_q == ST_PHYRST);
  assign poll_inc = (st_q == ST_POLL) && !phy_err && phy_done && !phy_rdy && !poll_last;
  assign gap_clr  = (st_q == ST_PHYRST) || (st_q == ST_POLL);
  assign gap_inc  = (st_q == ST_GAP) && !gap_last;

  always_comb begin
    unique case (st_q)
      ST_GATE:   op = OP_GATE;
      ST_PWR:    op = OP_PWR;
      ST_EN:     op = OP_EN;
      ST_OUT100: op = OP_OUT100;
      ST_CAP:    op = OP_CAP;
      ST_PORTS:  op = OP_PORTS;
      ST_TIMER:  op = OP_TIMER;
      default:   op = OP_NONE;
    endcase
  end

  assign phy_req   = (st_q == ST_PHYRST) || (st_q == ST_POLL);
  assign phy_wr    = (st_q == ST_PHYRST);
  assign phy_addr  = (st_q == ST_PHYRST) ? PHY_AW'(PHY_RST_REG) : PHY_AW'(PHY_STAT_REG);
  assign phy_wdata = (st_q == ST_PHYRST) ? PHY_DW'(1) : '0;

  assign busy      = !idle_like;
  assign done      = (st_q == ST_DONE);
  assign err       = (st_q == ST_FAIL);
  assign fail_step = fail_q;

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && !phy_done && !phy_err) |=> (phy_req && $stable(phy_addr)))
    else $error("PHY request dropped before an answer");

  // R8
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (fail_step != 3'd0))
    else $error("error state without a failure code");

  // R11
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done))
    else $error("busy and done together");

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import bringup_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 32,
  parameter int                PHY_AW     = 16,
  parameter int                PHY_DW     = 16,
  parameter int unsigned       BUS_HZ     = 132_000_000,
  parameter int unsigned       LOCK_POLLS = 100_000,
  parameter int unsigned       PHY_POLLS  = 50,
  parameter int unsigned       GAP_CYCLES = BUS_HZ / 10_000,
  parameter int unsigned       GATE_ADDR  = 32'h0010,
  parameter int unsigned       PLL_ADDR   = 32'h0020,
  parameter int unsigned       CAP_ADDR   = 32'h0100,
  parameter int unsigned       PORTS_ADDR = 32'h010C,
  parameter int unsigned       TIMER_ADDR = 32'h01E0,
  parameter logic [DATA_W-1:0] GATE_RST   = '0,
  parameter logic [DATA_W-1:0] PLL_RST    = DATA_W'(32'h0001_1000),
  parameter logic [DATA_W-1:0] CAP_RST    = '0,
  parameter logic [DATA_W-1:0] PORTS_RST  = '0,
  parameter int                SSS_BIT    = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pll_lock,
  input  logic              phy_done,
  input  logic              phy_err,
  input  logic [PHY_DW-1:0] phy_rdata,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              phy_req,
  output logic              phy_wr,
  output logic [PHY_AW-1:0] phy_addr,
  output logic [PHY_DW-1:0] phy_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [2:0]        fail_step
);
  localparam int unsigned       TIMER_VAL = BUS_HZ / 1000;
  localparam logic [PHY_DW-1:0] RDY_MASK  = PHY_DW'(1) << RXRDY_BIT;

  // Asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic   phy_rdy;
  logic   lock_clr, lock_inc, lock_last;
  logic   poll_clr, poll_inc, poll_last;
  logic   gap_clr, gap_inc, gap_last;
  wr_op_t op;

  assign phy_rdy = |(phy_rdata & RDY_MASK);

  bringup_fsm #(.PHY_AW(PHY_AW), .PHY_DW(PHY_DW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .pll_lock  (pll_lock),
    .phy_done  (phy_done),
    .phy_err   (phy_err),
    .phy_rdy   (phy_rdy),
    .lock_last (lock_last),
    .poll_last (poll_last),
    .gap_last  (gap_last),
    .lock_clr  (lock_clr),
    .lock_inc  (lock_inc),
    .poll_clr  (poll_clr),
    .poll_inc  (poll_inc),
    .gap_clr   (gap_clr),
    .gap_inc   (gap_inc),
    .op        (op),
    .phy_req   (phy_req),
    .phy_wr    (phy_wr),
    .phy_addr  (phy_addr),
    .phy_wdata (phy_wdata),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .fail_step (fail_step)
  );

  bringup_count #(.MAX_COUNT(LOCK_POLLS)) u_lock_cnt (
    .clk(clk), .rst_n(rst_sync_n), .clr(lock_clr), .inc(lock_inc), .at_last(lock_last)
  );

  bringup_count #(.MAX_COUNT(PHY_POLLS)) u_poll_cnt (
    .clk(clk), .rst_n(rst_sync_n), .clr(poll_clr), .inc(poll_inc), .at_last(poll_last)
  );

  bringup_count #(.MAX_COUNT(GAP_CYCLES)) u_gap_cnt (
    .clk(clk), .rst_n(rst_sync_n), .clr(gap_clr), .inc(gap_inc), .at_last(gap_last)
  );

  bringup_wr_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .GATE_ADDR(GATE_ADDR), .PLL_ADDR(PLL_ADDR), .CAP_ADDR(CAP_ADDR),
    .PORTS_ADDR(PORTS_ADDR), .TIMER_ADDR(TIMER_ADDR),
    .GATE_RST(GATE_RST), .PLL_RST(PLL_RST), .CAP_RST(CAP_RST), .PORTS_RST(PORTS_RST),
    .SSS_BIT(SSS_BIT), .TIMER_VAL(TIMER_VAL)
  ) u_wr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .op      (op),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  // R7
  timer_done_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_addr == ADDR_W'(TIMER_ADDR)) |-> done)
    else $error("timer write without done");

endmodule

// File: tb/link_bringup_seq_tb.sv
module link_bringup_seq_tb;

  localparam int          L       = 6;
  localparam int          P       = 3;
  localparam int          GAP     = 4;
  localparam int unsigned HZ      = 250_000;
  localparam logic [15:0] A_GATE  = 16'h0010;
  localparam logic [15:0] A_PLL   = 16'h0020;
  localparam logic [15:0] A_CAP   = 16'h0100;
  localparam logic [15:0] A_PORTS = 16'h010C;
  localparam logic [15:0] A_TMR   = 16'h01E0;
  localparam logic [31:0] R_GATE  = 32'h0000_00C3;
  localparam logic [31:0] R_PLL   = 32'h0001_1003;
  localparam logic [31:0] R_CAP   = 32'h4000_0010;
  localparam logic [31:0] R_PORTS = 32'h0000_0002;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pll_lock = 1'b0;
  logic        phy_done = 1'b0;
  logic        phy_err = 1'b0;
  logic [15:0] phy_rdata = '0;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic        phy_req, phy_wr;
  logic [15:0] phy_addr, phy_wdata;
  logic        busy, done, err;
  logic [2:0]  fail_step;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int pwr_cyc = 1 << 30;
  int run_wr_idx = 0;
  int lock_mode = 0;
  int rsp_ready_at = -1;
  int rsp_err_txn = -1;
  int txn_idx = 0;
  int reads_seen = 0;
  int last_done_cyc = 0;
  bit finished = 1'b0;

  logic [15:0] exp_a_q[$];
  logic [31:0] exp_d_q[$];
  string       exp_t_q[$];

  logic [31:0] m_gate = R_GATE;
  logic [31:0] m_pll  = R_PLL;
  logic [31:0] m_cap  = R_CAP;
  logic [31:0] m_pi   = R_PORTS;

  link_bringup_seq #(
    .BUS_HZ(HZ), .LOCK_POLLS(L), .PHY_POLLS(P), .GAP_CYCLES(GAP),
    .GATE_ADDR(32'(A_GATE)), .PLL_ADDR(32'(A_PLL)), .CAP_ADDR(32'(A_CAP)),
    .PORTS_ADDR(32'(A_PORTS)), .TIMER_ADDR(32'(A_TMR)),
    .GATE_RST(R_GATE), .PLL_RST(R_PLL), .CAP_RST(R_CAP), .PORTS_RST(R_PORTS),
    .SSS_BIT(27)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pll_lock(pll_lock),
    .phy_done(phy_done), .phy_err(phy_err), .phy_rdata(phy_rdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .phy_req(phy_req), .phy_wr(phy_wr), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .busy(busy), .done(done), .err(err), .fail_step(fail_step)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic push_wr(input logic [15:0] a, input logic [31:0] d, input string t);
    exp_a_q.push_back(a);
    exp_d_q.push_back(d);
    exp_t_q.push_back(t);
  endtask

  // Scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (wr_en) begin
      if (exp_a_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected write addr", wr_addr, 0);
      end else begin
        logic [15:0] ea;
        logic [31:0] ed;
        string       et;
        ea = exp_a_q.pop_front();
        ed = exp_d_q.pop_front();
        et = exp_t_q.pop_front();
        chk(wr_addr == ea, et, "write address", wr_addr, ea);
        chk(wr_data == ed, et, "write data", wr_data, ed);
        if (ea == A_TMR) chk(done == 1'b1, "R7", "done with timer write", done, 1);
        run_wr_idx++;
        if (run_wr_idx == 2) pwr_cyc = cyc;
      end
    end
  end

  // Lock driver
  initial forever begin
    @(negedge clk);
    if (lock_mode == 1 && cyc == pwr_cyc + L - 1) pll_lock = 1'b1;
    if (lock_mode == 2 && cyc == pwr_cyc + L)     pll_lock = 1'b1;
  end

  // PHY-access port responder
  initial forever begin
    @(negedge clk);
    if (phy_req) begin
      logic [15:0] a0;
      bit          rd;
      rd = (txn_idx != 0);
      a0 = phy_addr;
      if (!rd) begin
        chk(phy_wr == 1'b1, "R5", "reset is a write", phy_wr, 1);
        chk(phy_addr == 16'h7F3F, "R5", "reset address", phy_addr, 16'h7F3F);
        chk(phy_wdata == 16'h0001, "R5", "reset data", phy_wdata, 1);
      end else begin
        chk(phy_wr == 1'b0, "R6", "poll is a read", phy_wr, 0);
        chk(phy_addr == 16'h2003, "R6", "poll address", phy_addr, 16'h2003);
        chk(cyc - last_done_cyc == GAP, "R6", "gap before read", cyc - last_done_cyc, GAP);
        reads_seen++;
      end
      repeat (2) @(negedge clk);
      chk(phy_req == 1'b1 && phy_addr == a0, "R5", "request held", phy_req, 1);
      phy_done  = 1'b1;
      phy_err   = (txn_idx == rsp_err_txn);
      phy_rdata = (rd && (reads_seen - 1) == rsp_ready_at) ? 16'h0002 : 16'hFFFD;
      @(negedge clk);
      phy_done  = 1'b0;
      phy_err   = 1'b0;
      phy_rdata = '0;
      last_done_cyc = cyc;
      txn_idx++;
    end
  end

  // Watchdog
  initial begin
    repeat (150_000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  // lmode: 0 lock before start, 1 lock on last sample, 2 lock one sample late
  task automatic run_case(input int lmode, input int ready_at, input int err_txn,
                          input bit mid_start, input int exp_fail, input int exp_reads);
    string fr;
    int    guard;
    pll_lock     = (lmode == 0);
    lock_mode    = lmode;
    rsp_ready_at = ready_at;
    rsp_err_txn  = err_txn;
    txn_idx      = 0;
    reads_seen   = 0;
    run_wr_idx   = 0;
    pwr_cyc      = 1 << 30;
    m_gate = m_gate | 32'h30;
    push_wr(A_GATE, m_gate, "R2/R10 gate");
    m_pll = m_pll & ~(32'h1 << 12);
    push_wr(A_PLL, m_pll, "R3 power-up");
    if (exp_fail != 1) begin
      m_pll = (m_pll | (32'h1 << 13)) & ~(32'h1 << 16);
      push_wr(A_PLL, m_pll, "R4 enable");
      m_pll = m_pll | (32'h1 << 20);
      push_wr(A_PLL, m_pll, "R4 out100");
      if (exp_fail == 0) begin
        m_cap = m_cap | (32'h1 << 27);
        push_wr(A_CAP, m_cap, "R7/R10 capability");
        m_pi = m_pi | 32'h1;
        push_wr(A_PORTS, m_pi, "R7/R10 ports");
        push_wr(A_TMR, HZ / 1000, "R7 timer");
      end
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11", "busy after start", busy, 1);
    chk(done == 1'b0 && err == 1'b0, "R2", "run relaunched", {done, err}, 0);
    if (mid_start) begin
      repeat (10) @(negedge clk);
      chk(busy == 1'b1, "R9", "busy before extra start", busy, 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!(done || err) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    case (exp_fail)
      1:       fr = "R3";
      4:       fr = "R6";
      0:       fr = "R7";
      default: fr = "R8";
    endcase
    chk(done == (exp_fail == 0), "R11", "done held", done, exp_fail == 0);
    chk(err == (exp_fail != 0), fr, "err held", err, exp_fail != 0);
    chk(fail_step == 3'(exp_fail), fr, "fail_step", fail_step, exp_fail);
    chk(busy == 1'b0, "R11", "busy after end", busy, 0);
    chk(exp_a_q.size() == 0, "R10", "writes outstanding", exp_a_q.size(), 0);
    chk(reads_seen == exp_reads, "R6", "status reads", reads_seen, exp_reads);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: held in reset
    chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1", "status in reset",
        {busy, done, err}, 0);
    chk(wr_en == 1'b0 && phy_req == 1'b0, "R1", "no traffic in reset", {wr_en, phy_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(fail_step == 3'd0, "R1", "fail_step after reset", fail_step, 0);
    chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1", "status after reset",
        {busy, done, err}, 0);

    // R3 R4 R6 R7: lock on the last sample, ready on the last read
    run_case(1, P - 1, -1, 1'b0, 0, P);
    // R3: lock one sample too late
    run_case(2, 0, -1, 1'b0, 1, 0);
    // R9: extra start mid-run, ready on first read
    run_case(0, 0, -1, 1'b1, 0, 1);
    // R6: never ready
    run_case(0, -1, -1, 1'b0, 4, P);
    // R8: done and error together on the reset access
    run_case(0, -1, 0, 1'b0, 2, 0);
    // R8: error on the second status read
    run_case(0, -1, 2, 1'b0, 3, 2);
    // R10: shadows carried into a clean run
    run_case(1, 1, -1, 1'b0, 0, 2);

    summary();
  end

endmodule